// File: doc/BRIEF.md
# Half-Sine Chip Pulse Shaper

This block shapes a serial stream of binary chips for one branch of an offset-QPSK baseband transmitter. Each chip is turned into a half-sine lobe four samples long. A chip of 1 gives a positive lobe and a chip of 0 gives the same lobe with the sign inverted. The output is a registered two's-complement sample word. A new sample is produced on every clock in which the sample-rate enable is high, so the sample rate is four times the chip rate.

There is no multiplier and no tap delay line. A 2-bit phase counter addresses a four-entry magnitude table, and a sign stage negates the looked-up magnitude when the chip is 0. On the enable that ends a lobe, the block latches the next chip from its serial input. In the following cycle it pulses a request strobe, so the upstream source can present the next chip. Branch offset, carrier mixing and conversion to analog all sit outside this block.

Top module: `hsine_shaper`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) clears the phase to 0 and the latched chip to 0, drives `sample_out` to 0 and `bit_req` low. The first lobe after reset therefore uses a chip value of 0, and its first sample is -24.
- R2: With the default 7-bit output, successive enabled samples within one lobe have magnitudes 24, 58, 58, 24, in that order, for phases 0 to 3.
- R3: `sample_out` is two's complement. A latched chip of 1 gives +magnitude and a latched chip of 0 gives -magnitude (for example, -24 is 7'b1101000).
- R4: Each latched chip produces exactly four enabled samples. `bit_in` is latched on the enable that produces phase 3, and it shapes the next four samples.
- R5: `bit_req` is high for exactly one clock: the clock after the enable that latched a new chip. It is low at all other times.
- R6: While `smp_en` is low, `sample_out` and the phase hold their values and `bit_req` stays low.
- R7: The output is registered. The sample selected by an enable at a rising edge appears after that edge and stays until the next enabled edge.
- R8: Changes on `bit_in` at any enable other than the phase-3 enable have no effect on the samples produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample-rate enable; one output sample per high cycle |
| bit_in | input | 1 | Serial chip value, sampled at the end of each lobe |
| sample_out | output | OUT_W (7) | Registered signed shaped sample |
| bit_req | output | 1 | One-cycle strobe after a chip has been taken |

## Verification
A sample is due one rising edge after the enable that selects it. The request strobe is due on the edge that follows the phase-3 enable, and it lasts one cycle. The bench changes inputs only between edges and compares both outputs at the falling edge after every rising edge. A behavioural model is advanced by the same edge, so every result is checked in the cycle it is due, and any early or late change shows up as a mismatch. Enable patterns include continuous, sparse and random gaps. Chip patterns include held, random and toggling-mid-lobe, and reset is applied mid-stream.

// File: rtl/hsine_pkg.sv
package hsine_pkg;
    localparam int PH_N = 4;
    localparam int PH_W = $clog2(PH_N);
    localparam int REF_FULL = 63;
    typedef logic [PH_W-1:0] phase_t;
endpackage

// File: rtl/hs_phase_ctr.sv
module hs_phase_ctr
    import hsine_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   adv,
    output phase_t phase,
    output logic   wrap
);
    typedef struct packed {
        phase_t ph;
    } ctr_s;

    ctr_s ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (adv) begin
            ctr_d.ph = ctr_q.ph + phase_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign phase = ctr_q.ph;
    assign wrap  = adv && (ctr_q.ph == phase_t'(PH_N - 1));

    p_phase_step_r4: assert property (@(posedge clk) disable iff (rst)
        adv |=> (phase == $past(phase) + phase_t'(1)));

    p_phase_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(phase));
endmodule

// File: rtl/hs_mag_rom.sv
module hs_mag_rom
    import hsine_pkg::*;
#(
    parameter int MAG_W = 6
)(
    input  phase_t             idx,
    output logic [MAG_W-1:0]   mag
);
    localparam int FULL = (1 << MAG_W) - 1;

    function automatic logic [MAG_W-1:0] scale(input int base);
        return MAG_W'((base * FULL) / REF_FULL);
    endfunction

    always_comb begin
        case (idx)
            phase_t'(0): mag = scale(24);
            phase_t'(1): mag = scale(58);
            phase_t'(2): mag = scale(58);
            default:     mag = scale(24);
        endcase
    end

    always_comb begin
        p_mag_nonzero_r2: assert (mag != '0);
    end
endmodule

// File: rtl/hs_sign_sel.sv
module hs_sign_sel #(
    parameter int OUT_W = 7
)(
    input  logic [OUT_W-2:0] mag,
    input  logic             pos,
    output logic [OUT_W-1:0] val
);
    logic [OUT_W-1:0] ext;

    always_comb begin
        ext = {1'b0, mag};
        if (pos) begin
            val = ext;
        end else begin
            val = ~ext + OUT_W'(1);
        end
    end
endmodule

// File: rtl/hsine_shaper.sv
module hsine_shaper
    import hsine_pkg::*;
#(
    parameter int OUT_W = 7
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_en,
    input  logic             bit_in,
    output logic [OUT_W-1:0] sample_out,
    output logic             bit_req
);
    localparam int MAG_W = OUT_W - 1;

    typedef struct packed {
        logic             chip;
        logic [OUT_W-1:0] smp;
        logic             req;
    } st_s;

    st_s st_d, st_q;

    phase_t           phase;
    logic             wrap;
    logic [MAG_W-1:0] mag;
    logic [OUT_W-1:0] lobe_val;

    hs_phase_ctr u_ctr (
        .clk   (clk),
        .rst   (rst),
        .adv   (smp_en),
        .phase (phase),
        .wrap  (wrap)
    );

    hs_mag_rom #(.MAG_W(MAG_W)) u_rom (
        .idx (phase),
        .mag (mag)
    );

    hs_sign_sel #(.OUT_W(OUT_W)) u_sign (
        .mag (mag),
        .pos (st_q.chip),
        .val (lobe_val)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (smp_en) begin
            st_d.smp = lobe_val;
        end
        if (wrap) begin
            st_d.chip = bit_in;
            st_d.req  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_out = st_q.smp;
    assign bit_req    = st_q.req;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (sample_out == '0 && !bit_req));

    p_req_single_r5: assert property (@(posedge clk) disable iff (rst)
        bit_req |=> !bit_req);

    p_req_after_en_r5: assert property (@(posedge clk) disable iff (rst)
        bit_req |-> $past(smp_en));

    p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> ($stable(sample_out) && !bit_req));

    p_enabled_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
        smp_en |=> (sample_out != '0));
endmodule

// File: tb/hsine_shaper_test.sv
module hsine_shaper_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_en = 1'b0;
    logic       bit_in = 1'b0;
    logic [6:0] sample_out;
    logic       bit_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int mag_tab [4] = '{24, 58, 58, 24};
    int m_ph = 0;
    int m_chip = 0;
    int m_smp = 0;
    int m_req = 0;
    logic cur_din = 1'b0;

    always #10 clk = ~clk;

    hsine_shaper uut (
        .clk        (clk),
        .rst        (rst),
        .smp_en     (smp_en),
        .bit_in     (bit_in),
        .sample_out (sample_out),
        .bit_req    (bit_req)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_edge(input logic r, input logic en, input logic d);
        if (r) begin
            m_ph = 0; m_chip = 0; m_smp = 0; m_req = 0;
        end else begin
            m_req = 0;
            if (en) begin
                m_smp = (m_chip != 0) ? mag_tab[m_ph] : -mag_tab[m_ph];
                if (m_ph == 3) begin
                    m_chip = int'(d);
                    m_req = 1;
                end
                m_ph = (m_ph + 1) % 4;
            end
        end
    endtask

    task automatic step(input logic r, input logic en, input logic d, input string tag);
        rst = r; smp_en = en; bit_in = d;
        @(posedge clk);
        model_edge(r, en, d);
        @(negedge clk);
        check({tag, " sample"}, int'($signed(sample_out)), m_smp);
        check({tag, " R5 bit_req"}, int'(bit_req), m_req);
        if (bit_req) cur_din = 1'($urandom % 2);
    endtask

    initial begin
        @(negedge clk);
        step(1'b1, 1'b0, 1'b0, "R1 reset");
        step(1'b1, 1'b1, 1'b1, "R1 reset");
        check("R1 reset sample zero", int'(sample_out), 0);
        // R1: first lobe after reset is negative, first sample -24
        step(1'b0, 1'b1, 1'b1, "R1 first");
        check("R1 first sample -24", int'($signed(sample_out)), -24);
        check("R3 encoding 7'b1101000", int'(sample_out), 7'b1101000);
        // R2 R3 R4 R7: continuous enables, random chips
        for (int i = 0; i < 400; i++) step(1'b0, 1'b1, cur_din, "R2 R3 R4 R7 stream");
        // R6: sparse enables, hold while idle
        for (int i = 0; i < 600; i++)
            step(1'b0, ($urandom % 3) == 0, cur_din, "R6 sparse");
        // R8: input toggles every cycle, only the phase-3 value counts
        for (int i = 0; i < 600; i++)
            step(1'b0, ($urandom % 2) == 0, 1'($urandom % 2), "R8 toggling");
        // R1: reset mid-stream
        step(1'b1, 1'b1, 1'b1, "R1 midreset");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, "R1 R2 after reset");
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b1, "R3 positive lobes");
        check("R3 last positive sample", int'($signed(sample_out)), 24);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule